// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block watches eight request lines and records a request on each line's rising edge. It picks one request at a time and turns it into an 8-bit vector. The vector is held in a register that the processor can read. The block then raises one interrupt output and keeps it high until the processor writes an acknowledge. Among pending lines that are not masked, the lowest-numbered line wins. The vector is that line's number added to a programmable base, modulo 256.

A per-line mask holds back delivery but does not drop the request. A masked line stays pending and is delivered once its mask bit is cleared. While one interrupt is outstanding, nothing else is presented. Arbitration resumes once the acknowledge arrives.

Software uses a small register bus with three registers. Offset 0 reads the vector, and a write to it is the acknowledge. Offset 1 is the mask. Offset 2 is the vector base. Reads are combinational and writes take effect at the clock edge that samples them.

Top module: `pic_ctrl`

## Requirements
- R1: When several unmasked lines are pending, the vector delivered belongs to the lowest-numbered of them. The others are delivered later, one per acknowledge, in increasing line order.
- R2: The vector for line n is (base + n) mod 256. The base register at offset 2 reads 0x20 (32) after reset.
- R3: A write to offset 2 replaces the base, and the new value reads back at offset 2. Vectors chosen after the write use the new base. A vector that is already outstanding keeps its value.
- R4: A line's vector is readable at offset 0 one cycle before the interrupt output rises. The output rises at the second clock edge after the edge that first samples the line high, when no other request is in progress.
- R5: Once high, the interrupt output stays high until a write to offset 0. It is low after the edge that samples that write, and the write data value has no effect.
- R6: An acknowledge clears the serviced line's pending state, so that line is not delivered again. If another unmasked line is pending, the output rises again at the second edge after the acknowledge edge.
- R7: The mask is at offset 1 and reads 0 after reset. Bit n = 1 masks line n. A masked line's request stays pending with the output low, and it is delivered once the bit is cleared. A masked lower-numbered line does not block a higher-numbered one.
- R8: Only a rising edge on a line creates a request, so a line held high yields one delivery. A rising edge sampled in the same cycle as the acknowledge of that same line leaves a new pending request, which is delivered again.
- R9: While an interrupt is outstanding, a new request on a lower-numbered line does not change the vector at offset 0. A write to offset 0 while no interrupt is outstanding leaves every pending request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Request lines; a rising edge creates a request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| intr | output | 1 | Interrupt to the processor, held until acknowledge |

## Verification
The acknowledge that clears a line's pending bit can fall in the same cycle as a fresh rising edge on that same line. The bench provokes this by driving the line high and writing the acknowledge before one clock edge. It then judges the result by watching for a second delivery with the same vector. The bench also lands base and mask writes and a lower-numbered request while an interrupt is outstanding, and checks that the vector presented does not move.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } pic_state_e;

  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] OFS_VEC  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK = 2'd1;
  localparam logic [REG_ADDR_W-1:0] OFS_BASE = 2'd2;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] pending
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise;

  assign rise = lines & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q  <= lines;
      // a new edge outranks a clear landing in the same cycle
      pending <= (pending & ~clr_vec) | rise;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 valid,
  output logic [IDX_W-1:0]     idx
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign valid = |req;
  assign idx   = lowest_set(req);
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned BASE_RESET = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [VEC_W-1:0]      bus_wdata,
  output logic [NUM_LINES-1:0]  mask_q,
  output logic [VEC_W-1:0]      base_q,
  output logic                  ack_wr
);
  assign ack_wr = bus_wr && (bus_addr == OFS_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= VEC_W'(BASE_RESET);
    end else if (bus_wr) begin
      if (bus_addr == OFS_MASK) mask_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == OFS_BASE) base_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned BASE_RESET = 32,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_lines,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [VEC_W-1:0]      bus_wdata,
  output logic [VEC_W-1:0]      bus_rdata,
  output logic                  intr
);
  function automatic logic [VEC_W-1:0] vec_calc(input logic [VEC_W-1:0] base,
                                                input logic [IDX_W-1:0] n);
    return base + VEC_W'(n);
  endfunction

  pic_state_e           state_q;
  logic [VEC_W-1:0]     vec_q;
  logic [IDX_W-1:0]     svc_idx;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] clr_vec;
  logic [VEC_W-1:0]     base_q;
  logic                 ack_wr;
  logic                 ack_fire;
  logic                 grant_valid;
  logic [IDX_W-1:0]     grant_idx;
  logic                 armed;

  pic_regs #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .BASE_RESET(BASE_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q), .ack_wr(ack_wr)
  );

  pic_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .clr_vec(clr_vec), .pending(pending)
  );

  assign cand = pending & ~mask_q;

  pic_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
    .req(cand), .valid(grant_valid), .idx(grant_idx)
  );

  assign intr     = (state_q == ST_WAIT);
  assign armed    = (state_q == ST_ARMED);
  assign ack_fire = ack_wr && intr;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
    assign clr_vec[g] = ack_fire && (svc_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      svc_idx <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (grant_valid) begin
          vec_q   <= vec_calc(base_q, grant_idx);
          svc_idx <= grant_idx;
          state_q <= ST_ARMED;
        end
        ST_ARMED: state_q <= ST_WAIT;
        ST_WAIT:  if (ack_fire) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_VEC:  bus_rdata = vec_q;
      OFS_MASK: bus_rdata = VEC_W'(mask_q);
      OFS_BASE: bus_rdata = base_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_W     = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 intr,
  input logic                 armed,
  input logic                 ack_fire,
  input logic [VEC_W-1:0]     vec_q,
  input logic                 grant_valid,
  input logic [IDX_W-1:0]     grant_idx,
  input logic [NUM_LINES-1:0] cand,
  input logic [NUM_LINES-1:0] mask_q
);
  logic [NUM_LINES-1:0] below;
  assign below = (NUM_LINES'(1) << grant_idx) - NUM_LINES'(1);

  p_lowest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (cand[grant_idx] && ((cand & below) == '0)));

  p_masked_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !mask_q[grant_idx]);

  p_loaded_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(armed));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !ack_fire) |=> intr);

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !intr);

  p_vec_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !ack_fire) |=> $stable(vec_q));
endmodule

bind pic_ctrl pic_ctrl_chk #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .intr(intr), .armed(armed), .ack_fire(ack_fire),
  .vec_q(vec_q), .grant_valid(grant_valid), .grant_idx(grant_idx),
  .cand(cand), .mask_q(mask_q)
);

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       intr;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intr(intr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    irq_lines = m;
    @(posedge clk); #1;
    irq_lines = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_intr(output bit ok);
    ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (intr) begin ok = 1; break; end
    end
  endtask

  function automatic int exp_vec(input int base, input int n);
    return (base + n) % 256;
  endfunction

  // expect an interrupt carrying vector exp, then acknowledge it
  task automatic take(input string req, input int exp);
    bit ok;
    logic [7:0] v;
    wait_intr(ok);
    chk({req, " intr raised"}, ok, 1);
    rd(2'd0, v);
    chk({req, " vector"}, v, exp);
    wr(2'd0, 8'h5A);
    chk({req, " intr low after ack"}, intr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit ok;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // reset state
    chk("R5 reset intr", intr, 0);
    rd(2'd2, v); chk("R2 reset base", v, 32);
    rd(2'd1, v); chk("R7 reset mask", v, 0);

    // R4/R5/R6: every single line, exact timing
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      irq_lines = 8'(1 << n);
      @(posedge clk); #1;
      chk("R4 low after sampling edge", intr, 0);
      @(posedge clk); #1;
      chk("R4 low one edge later", intr, 0);
      rd(2'd0, v); chk("R4 vector ready before intr / R2", v, exp_vec(32, n));
      irq_lines = '0;
      @(posedge clk); #1;
      chk("R4 intr at second edge", intr, 1);
      idle(4);
      chk("R5 intr held", intr, 1);
      wr(2'd0, 8'(n * 37));
      chk("R5 intr drops on ack", intr, 0);
      idle(6);
      chk("R6 serviced line not redelivered", intr, 0);
    end

    // R1/R6: all pairs at once
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        pulse(8'((1 << i) | (1 << j)));
        take("R1 lower of pair", exp_vec(32, i));
        @(posedge clk); #1;
        chk("R6 low one edge after ack", intr, 0);
        @(posedge clk); #1;
        chk("R6 next rises at second edge", intr, 1);
        take("R6 higher of pair", exp_vec(32, j));
      end
    end

    // R1: three lines, in order
    pulse(8'b1010_0100);
    take("R1 three-way first", 34);
    take("R1 three-way second", 37);
    take("R1 three-way third", 39);

    // R2/R3: base change with wraparound
    wr(2'd2, 8'hFC);
    rd(2'd2, v); chk("R3 base readback", v, 8'hFC);
    pulse(8'h20);
    take("R2 wrap", exp_vec(252, 5));
    pulse(8'h01);
    take("R3 new base", 252);
    wr(2'd2, 8'd32);

    // R7: masked request kept
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R7 mask readback", v, 4);
    pulse(8'h04);
    idle(8);
    chk("R7 masked stays quiet", intr, 0);
    wr(2'd1, 8'h00);
    take("R7 delivered on unmask", 34);

    // R7: masked low line does not block higher line
    wr(2'd1, 8'h01);
    pulse(8'h09);
    take("R7 higher line passes", 35);
    idle(4);
    chk("R7 no delivery while masked", intr, 0);
    wr(2'd1, 8'h00);
    take("R7 low line after unmask", 32);

    // R8: held line delivers once
    @(negedge clk); irq_lines = 8'h02;
    take("R8 held line first", 33);
    idle(10);
    chk("R8 held line once", intr, 0);
    @(negedge clk); irq_lines = '0;

    // R9/R3: outstanding vector frozen
    pulse(8'h10);
    wait_intr(ok);
    chk("R9 intr for line 4", ok, 1);
    pulse(8'h01);
    wr(2'd2, 8'h50);
    idle(4);
    rd(2'd0, v); chk("R9 vector frozen", v, 36);
    chk("R3 outstanding vector keeps old base", v, 36);
    wr(2'd0, 8'h00);
    take("R3 later vector uses new base", 8'h50);
    rd(2'd2, v); chk("R3 base readback", v, 8'h50);
    wr(2'd2, 8'd32);

    // R9: ack while idle leaves pending intact
    wr(2'd1, 8'h40);
    pulse(8'h40);
    idle(3);
    wr(2'd0, 8'hFF);
    idle(3);
    chk("R9 idle ack no intr", intr, 0);
    wr(2'd1, 8'h00);
    take("R9 pending kept through idle ack", 38);

    // R8: edge and ack of same line in one cycle
    pulse(8'h04);
    wait_intr(ok);
    chk("R8 first delivery", ok, 1);
    @(negedge clk);
    irq_lines = 8'h04;
    bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    chk("R8 ack taken", intr, 0);
    take("R8 same-cycle edge redelivered", 34);
    @(negedge clk); irq_lines = '0;
    idle(6);
    chk("R8 no third delivery", intr, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule